// File: doc/BRIEF.md
# Multicycle 8-bit Core with a Greatest-Common-Divisor Instruction

This block is a small 8-bit processor core whose controller is one state machine. Each instruction takes several clock cycles. Register A, register B, a 4-bit flag register and the instruction register carry values from one state to the next. The core runs three instructions:

- a no-operation,
- a LOAD that copies a data-memory word into A or B,
- a GCD instruction that reduces A and B by repeated subtraction until they agree, then stores the result in data memory.

Instruction memory and data memory are internal arrays. A write port at the block's edge fills them, normally while reset is held. A combinational observe port reads any data-memory word.

A typical program has four words: a no-operation, a LOAD of address 0 into A, a LOAD of address 1 into B, and GCD. GCD loops through these states: compare, wait, then either subtract A or swap/compute/subtract B, a loop-back state, and compare again. The loop ends when the compare reports equal operands or a zero operand. The core then jumps to the result path, writes data address 2 and fetches again.

The states and their codes are:

| Code | State | Role |
|------|-------|------|
| 0 | FETCH | fetch |
| 1 | DECODE | decode |
| 2 | LD_EXEC | load execute |
| 3 | LD_READ | load memory read |
| 4 | LD_WB | load writeback |
| 5 | CMP | compare |
| 6 | WAIT | wait |
| 7 | WB_X | write A−B into A |
| 8 | LOOP | loop back to compare |
| 9 | SWAP | swap operands |
| 10 | SUB | compute B−A |
| 11 | WB_Y | write B−A into B |
| 12 | RES_JMP | result jump |
| 13 | RES_WR | result write |

The transitions are:

- FETCH goes to FETCH or DECODE.
- DECODE goes to LD_EXEC or CMP.
- LD_EXEC goes to LD_READ, then LD_WB, then FETCH.
- CMP goes to WAIT.
- WAIT goes to WB_X, SWAP or RES_JMP.
- WB_X goes to LOOP.
- SWAP goes to SUB, then WB_Y, then LOOP.
- LOOP goes to CMP.
- RES_JMP goes to RES_WR, then FETCH.

Top module: `gcd_mc_core`

## Requirements
- R1: A synchronous active-high `rst` puts the core in FETCH, sets the program counter to 0, clears A, B and the flags to 0, and clears the instruction register to a no-operation.
- R2: In FETCH the core loads the word at instruction address `pc` and increments `pc` by one, wrapping from 31 to 0. If the fetched opcode is 00 or 11, the core stays in FETCH (no-operation). Otherwise it moves to DECODE. `pc` changes in no other state.
- R3: Instruction word layout: bits [7:6] hold the opcode (00 no-operation, 01 LOAD, 10 GCD). Bit 5 selects the LOAD target (0 for A, 1 for B). Bits [4:0] hold the LOAD data address. A LOAD runs DECODE, LD_EXEC, LD_READ, LD_WB, then FETCH. The target register takes the memory word at the end of LD_WB.
- R4: GCD runs DECODE, then CMP, then exactly one WAIT. At the end of CMP the flags take one of four codes:
  - 0001 if A or B is zero;
  - 1100 if A > B;
  - 0010 if A < B;
  - 1001 if A equals B and is nonzero.
  The flags keep their value in every other state.
- R5: With flags 1100, WAIT leads to WB_X, which writes A−B into A. WB_X leads to LOOP and then to CMP.
- R6: With flags 0010, WAIT leads to SWAP, then SUB, then WB_Y, which writes B−A into B. WB_Y leads to LOOP and then to CMP. A is not changed on this path.
- R7: With flags 1001 or 0001, WAIT leads to RES_JMP, then RES_WR, then FETCH. RES_WR stores a value to data address 2: A when the flags are 1001, otherwise A OR B (the nonzero operand, or 0 if both are zero).
- R8: Take the program no-operation, LOAD A from 0, LOAD B from 1, GCD, with operands 187 and 119. Data address 2 reads 17, with the core in FETCH, after exactly 43 active clock edges from reset release, that is, in the 44th cycle.
- R9: An external data-memory write and the core's RES_WR store can land on the same clock edge. In that case the external write takes effect and the core's store is dropped.
- R10: When `ld_en` is high, the rising edge writes `ld_data` to address `ld_addr`. The target is instruction memory if `ld_imem` is 1 and data memory otherwise, and this works in any state, including reset. `obs_data` shows data word `obs_addr` combinationally.
- R11: `state_o` shows the state in the code listed in the table above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | External memory write enable |
| ld_imem | input | 1 | 1 selects instruction memory, 0 data memory |
| ld_addr | input | 5 | External write address |
| ld_data | input | 8 | External write data |
| obs_addr | input | 5 | Data memory observe address |
| obs_data | output | 8 | Data memory word at `obs_addr` |
| state_o | output | 4 | Current controller state code |
| pc_o | output | 5 | Program counter |
| reg_a_o | output | 8 | Register A |
| reg_b_o | output | 8 | Register B |
| flags_o | output | 4 | Compare flag code |

## Verification
The two functions that can fall in the same cycle are the core's own result store in RES_WR and an external write to data memory at address 2. The bench drives an external write of 0x5A to address 2 in exactly the RES_WR cycle that its reference model predicts. It then judges that the observe port shows 0x5A one edge later, not the computed result, and that the core has still returned to FETCH. Every other cycle of each program is compared against the model's state, A, B, flag and program-counter trace.

// File: rtl/gcd_mc_pkg.sv
package gcd_mc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_LD_EXEC = 4'd2,
        ST_LD_READ = 4'd3,
        ST_LD_WB   = 4'd4,
        ST_CMP     = 4'd5,
        ST_WAIT    = 4'd6,
        ST_WB_X    = 4'd7,
        ST_LOOP    = 4'd8,
        ST_SWAP    = 4'd9,
        ST_SUB     = 4'd10,
        ST_WB_Y    = 4'd11,
        ST_RES_JMP = 4'd12,
        ST_RES_WR  = 4'd13
    } state_t;

    localparam logic [1:0] OP_NOP  = 2'b00;
    localparam logic [1:0] OP_LOAD = 2'b01;
    localparam logic [1:0] OP_GCD  = 2'b10;

    localparam logic [3:0] FL_NONE = 4'b0000;
    localparam logic [3:0] FL_GT   = 4'b1100;
    localparam logic [3:0] FL_LT   = 4'b0010;
    localparam logic [3:0] FL_EQ   = 4'b1001;
    localparam logic [3:0] FL_ZERO = 4'b0001;

endpackage

// File: rtl/gcd_mc_mem.sv
module gcd_mc_mem #(
    parameter int DW  = 8,
    parameter int AW  = 5,
    parameter int NRD = 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = mem[raddr[i]];
    end

endmodule

// File: rtl/gcd_mc_ctrl.sv
module gcd_mc_ctrl
    import gcd_mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fetch_op,
    input  logic [1:0] ir_op,
    input  logic [3:0] flags,
    output state_t     state
);
    state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH: begin
                if (fetch_op == OP_LOAD || fetch_op == OP_GCD) begin
                    nxt = ST_DECODE;
                end else begin
                    nxt = ST_FETCH;
                end
            end
            ST_DECODE: begin
                if (ir_op == OP_LOAD) begin
                    nxt = ST_LD_EXEC;
                end else if (ir_op == OP_GCD) begin
                    nxt = ST_CMP;
                end else begin
                    nxt = ST_FETCH;
                end
            end
            ST_LD_EXEC: nxt = ST_LD_READ;
            ST_LD_READ: nxt = ST_LD_WB;
            ST_LD_WB:   nxt = ST_FETCH;
            ST_CMP:     nxt = ST_WAIT;
            ST_WAIT: begin
                if (flags == FL_GT) begin
                    nxt = ST_WB_X;
                end else if (flags == FL_LT) begin
                    nxt = ST_SWAP;
                end else if (flags == FL_EQ || flags == FL_ZERO) begin
                    nxt = ST_RES_JMP;
                end else begin
                    nxt = ST_FETCH;
                end
            end
            ST_WB_X:    nxt = ST_LOOP;
            ST_SWAP:    nxt = ST_SUB;
            ST_SUB:     nxt = ST_WB_Y;
            ST_WB_Y:    nxt = ST_LOOP;
            ST_LOOP:    nxt = ST_CMP;
            ST_RES_JMP: nxt = ST_RES_WR;
            ST_RES_WR:  nxt = ST_FETCH;
            default:    nxt = ST_FETCH;
        endcase
    end

    p_fetch_exit_r2: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> (state == ST_FETCH || state == ST_DECODE));

    p_one_wait_r4: assert property (@(posedge clk) disable iff (rst)
        state == ST_CMP |=> state == ST_WAIT);

    p_loop_back_r5: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOOP |=> state == ST_CMP);

    p_store_ends_r7: assert property (@(posedge clk) disable iff (rst)
        state == ST_RES_WR |=> state == ST_FETCH);

endmodule

// File: rtl/gcd_mc_datapath.sv
module gcd_mc_datapath
    import gcd_mc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  state_t              state,
    input  logic [DW-1:0]       imem_rd,
    input  logic [DW-1:0]       dmem_rd,
    output logic [DW-4:0]       pc,
    output logic [1:0]          ir_op,
    output logic [DW-1:0]       reg_a,
    output logic [DW-1:0]       reg_b,
    output logic [3:0]          flags,
    output logic [DW-4:0]       dmem_raddr,
    output logic                core_we,
    output logic [DW-1:0]       core_wdata
);
    localparam int AW = DW - 3;

    logic          ir_dst;
    logic [AW-1:0] ir_adr;
    logic [AW-1:0] mar;
    logic [DW-1:0] mdr;
    logic [DW-1:0] op_x;
    logic [DW-1:0] op_y;
    logic [DW-1:0] res;
    logic [3:0]    flag_nxt;

    // compare unit: zero guard has priority over magnitude
    always_comb begin
        if (reg_a == '0 || reg_b == '0) begin
            flag_nxt = FL_ZERO;
        end else if (reg_a > reg_b) begin
            flag_nxt = FL_GT;
        end else if (reg_a < reg_b) begin
            flag_nxt = FL_LT;
        end else begin
            flag_nxt = FL_EQ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir_op  <= OP_NOP;
            ir_dst <= 1'b0;
            ir_adr <= '0;
            reg_a  <= '0;
            reg_b  <= '0;
            flags  <= FL_NONE;
            mar    <= '0;
            mdr    <= '0;
            op_x   <= '0;
            op_y   <= '0;
            res    <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir_op  <= imem_rd[DW-1 -: 2];
                    ir_dst <= imem_rd[DW-3];
                    ir_adr <= imem_rd[AW-1:0];
                    pc     <= pc + 1'b1;
                end
                ST_LD_EXEC: mar <= ir_adr;
                ST_LD_READ: mdr <= dmem_rd;
                ST_LD_WB: begin
                    if (ir_dst) begin
                        reg_b <= mdr;
                    end else begin
                        reg_a <= mdr;
                    end
                end
                ST_CMP:  flags <= flag_nxt;
                ST_WB_X: reg_a <= reg_a - reg_b;
                ST_SWAP: begin
                    op_x <= reg_b;
                    op_y <= reg_a;
                end
                ST_SUB:  res   <= op_x - op_y;
                ST_WB_Y: reg_b <= res;
                ST_RES_JMP: begin
                    if (flags == FL_EQ) begin
                        res <= reg_a;
                    end else begin
                        res <= reg_a | reg_b;
                    end
                end
                default: ;
            endcase
        end
    end

    assign dmem_raddr = mar;
    assign core_we    = (state == ST_RES_WR);
    assign core_wdata = res;

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        state != ST_FETCH |=> $stable(pc));

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        state != ST_CMP |=> $stable(flags));

    p_flag_code_r4: assert property (@(posedge clk) disable iff (rst)
        state == ST_WAIT |-> (flags == FL_GT || flags == FL_LT ||
                              flags == FL_EQ || flags == FL_ZERO));

    p_sub_a_r5: assert property (@(posedge clk) disable iff (rst)
        state == ST_WB_X |=> reg_a == DW'($past(reg_a) - $past(reg_b)));

    p_sub_b_r6: assert property (@(posedge clk) disable iff (rst)
        state == ST_WB_Y |=> (reg_b == DW'($past(reg_b) - $past(reg_a))
                              && $stable(reg_a)));

endmodule

// File: rtl/gcd_mc_core.sv
module gcd_mc_core
    import gcd_mc_pkg::*;
#(
    parameter int DW       = 8,
    parameter int RES_ADDR = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic            ld_imem,
    input  logic [DW-4:0]   ld_addr,
    input  logic [DW-1:0]   ld_data,
    input  logic [DW-4:0]   obs_addr,
    output logic [DW-1:0]   obs_data,
    output logic [3:0]      state_o,
    output logic [DW-4:0]   pc_o,
    output logic [DW-1:0]   reg_a_o,
    output logic [DW-1:0]   reg_b_o,
    output logic [3:0]      flags_o
);
    localparam int AW = DW - 3;

    state_t        state;
    logic [AW-1:0] pc;
    logic [1:0]    ir_op;
    logic [3:0]    flags;
    logic [DW-1:0] reg_a;
    logic [DW-1:0] reg_b;
    logic [AW-1:0] dm_core_ra;
    logic          core_we;
    logic [DW-1:0] core_wdata;

    logic [AW-1:0] im_ra [1];
    logic [DW-1:0] im_rd [1];
    logic [AW-1:0] dm_ra [2];
    logic [DW-1:0] dm_rd [2];

    logic          ext_dm;
    logic          dm_we;
    logic [AW-1:0] dm_wa;
    logic [DW-1:0] dm_wd;

    assign im_ra[0] = pc;
    assign dm_ra[0] = dm_core_ra;
    assign dm_ra[1] = obs_addr;

    // external write wins a same-edge collision with the result store
    assign ext_dm = ld_en & ~ld_imem;
    assign dm_we  = ext_dm | core_we;
    assign dm_wa  = ext_dm ? ld_addr : AW'(RES_ADDR);
    assign dm_wd  = ext_dm ? ld_data : core_wdata;

    gcd_mc_mem #(.DW(DW), .AW(AW), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (ld_en & ld_imem),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (im_ra),
        .rdata (im_rd)
    );

    gcd_mc_mem #(.DW(DW), .AW(AW), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_wa),
        .wdata (dm_wd),
        .raddr (dm_ra),
        .rdata (dm_rd)
    );

    gcd_mc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fetch_op (im_rd[0][DW-1 -: 2]),
        .ir_op    (ir_op),
        .flags    (flags),
        .state    (state)
    );

    gcd_mc_datapath #(.DW(DW)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .imem_rd    (im_rd[0]),
        .dmem_rd    (dm_rd[0]),
        .pc         (pc),
        .ir_op      (ir_op),
        .reg_a      (reg_a),
        .reg_b      (reg_b),
        .flags      (flags),
        .dmem_raddr (dm_core_ra),
        .core_we    (core_we),
        .core_wdata (core_wdata)
    );

    assign obs_data = dm_rd[1];
    assign state_o  = state;
    assign pc_o     = pc;
    assign reg_a_o  = reg_a;
    assign reg_b_o  = reg_b;
    assign flags_o  = flags;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (state == ST_FETCH && pc == '0 && flags == FL_NONE));

endmodule

// File: tb/gcd_mc_core_bench.sv
module gcd_mc_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic       ld_imem = 1'b0;
    logic [4:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [4:0] obs_addr = 5'd2;
    logic [7:0] obs_data;
    logic [3:0] state_o;
    logic [4:0] pc_o;
    logic [7:0] reg_a_o;
    logic [7:0] reg_b_o;
    logic [3:0] flags_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    int im [32];
    int dm [32];
    int q_st[$], q_a[$], q_b[$], q_f[$], q_pc[$];
    int m_a, m_b, m_f, m_pc, exp_res;

    gcd_mc_core u_gcd_mc_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_imem(ld_imem),
        .ld_addr(ld_addr), .ld_data(ld_data), .obs_addr(obs_addr),
        .obs_data(obs_data), .state_o(state_o), .pc_o(pc_o),
        .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .flags_o(flags_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(int s);
        q_st.push_back(s);
        q_a.push_back(m_a);
        q_b.push_back(m_b);
        q_f.push_back(m_f);
        q_pc.push_back(m_pc);
    endtask

    // instruction-level model emitting the expected per-cycle trace
    task automatic build();
        int d [32];
        bit done = 0;
        q_st.delete(); q_a.delete(); q_b.delete(); q_f.delete(); q_pc.delete();
        m_a = 0; m_b = 0; m_f = 0; m_pc = 0;
        foreach (dm[i]) d[i] = dm[i];
        while (!done) begin
            int ins = im[m_pc];
            int op = (ins >> 6) & 3;
            push(0);
            m_pc = (m_pc + 1) & 31;
            if (op == 0 || op == 3) continue;
            push(1);
            if (op == 1) begin
                push(2); push(3); push(4);
                if (ins & 32) m_b = d[ins & 31];
                else m_a = d[ins & 31];
            end else begin
                while (1) begin
                    push(5);
                    if (m_a == 0 || m_b == 0) m_f = 1;
                    else if (m_a > m_b) m_f = 12;
                    else if (m_a < m_b) m_f = 2;
                    else m_f = 9;
                    push(6);
                    if (m_f == 12) begin
                        push(7); m_a = (m_a - m_b) & 255; push(8);
                    end else if (m_f == 2) begin
                        push(9); push(10); push(11); m_b = (m_b - m_a) & 255; push(8);
                    end else begin
                        push(12); push(13);
                        exp_res = (m_f == 9) ? m_a : (m_a | m_b);
                        done = 1;
                        break;
                    end
                end
            end
        end
    endtask

    function automatic string tag(int s);
        if (s == 0) return "R2";
        if (s <= 4) return "R3";
        if (s <= 6) return "R4";
        if (s == 7 || s == 8) return "R5";
        if (s <= 11) return "R6";
        return "R7";
    endfunction

    task automatic run_case(int first, int opa, int opb, int init2,
                            bit collide, bit timing);
        int n;
        foreach (im[i]) im[i] = 0;
        foreach (dm[i]) dm[i] = 0;
        im[0] = first; im[1] = 8'h40; im[2] = 8'h61; im[3] = 8'h80;
        dm[0] = opa; dm[1] = opb; dm[2] = init2;
        build();
        n = q_st.size();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            ld_en = 1'b1; ld_imem = 1'b1; ld_addr = 5'(i); ld_data = 8'(im[i]);
            @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            ld_en = 1'b1; ld_imem = 1'b0; ld_addr = 5'(i); ld_data = 8'(dm[i]);
            @(negedge clk);
        end
        ld_en = 1'b0;
        rst = 1'b0;
        #1;
        check(state_o == 0 && pc_o == 0 && reg_a_o == 0 && reg_b_o == 0 && flags_o == 0,
              "R1 reset state", {state_o, pc_o}, 0);
        check(obs_data == 8'(init2), "R10 preload observe", obs_data, init2);
        for (int k = 0; k < n; k++) begin
            if (k > 0) #1;
            checks = checks + 1;
            if (state_o != q_st[k] || reg_a_o != q_a[k] || reg_b_o != q_b[k] ||
                flags_o != q_f[k] || pc_o != q_pc[k]) begin
                failures = failures + 1;
                $display("FAIL %s/R11 cycle %0d: actual st=%0d a=%0d b=%0d f=%b pc=%0d expected st=%0d a=%0d b=%0d f=%b pc=%0d",
                         tag(q_st[k]), k + 1, state_o, reg_a_o, reg_b_o, flags_o, pc_o,
                         q_st[k], q_a[k], q_b[k], 4'(q_f[k]), q_pc[k]);
            end
            if (timing && k == n - 1)
                check(obs_data == 0, "R8 no result before cycle 44", obs_data, 0);
            if (collide && k == n - 1) begin
                ld_en = 1'b1; ld_imem = 1'b0; ld_addr = 5'd2; ld_data = 8'h5A;
            end
            @(negedge clk);
            ld_en = 1'b0;
        end
        #1;
        if (collide) begin
            check(obs_data == 8'h5A, "R9 external write wins", obs_data, 8'h5A);
        end else begin
            check(obs_data == 8'(exp_res), "R7 stored result", obs_data, exp_res);
        end
        check(state_o == 0, "R7 return to fetch", state_o, 0);
        if (timing)
            check(n == 43 && obs_data == 8'd17, "R8 result 17 after 43 edges", n * 1000 + obs_data, 43017);
    endtask

    initial begin
        run_case(8'h00, 187, 119, 0,    1'b0, 1'b1);
        run_case(8'h00, 0,   9,   8'h33, 1'b0, 1'b0);
        run_case(8'h00, 0,   0,   8'hEE, 1'b0, 1'b0);
        run_case(8'h00, 255, 1,   0,    1'b0, 1'b0);
        run_case(8'hC0, 21,  35,  0,    1'b0, 1'b0);
        run_case(8'h00, 48,  0,   0,    1'b0, 1'b0);
        run_case(8'h00, 12,  12,  0,    1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule